// File: doc/BRIEF.md
# Display Power-Up and Standby Sequencer

This block sits on the host side of a display driver whose logic domain and charge pump are powered separately. It drives the logic-domain enable, the pump enable and the pump's boost clock in a fixed order. It tells an external frame writer when a frame may be sent. It also controls the driver's output-enable strobe, both for showing a frame and for forcing every segment output to the low level. Each waiting interval is a parameter counted in system-clock cycles: the logic-up wait, pump settling, the optional uniform pre-drive, the display hold, the low hold before standby, and the gap between power steps.

A start request wakes the domains in order: logic first, then pump, then the pump clock. After settling, the block waits for frames. Each frame the writer reports ready is shown for a fixed drive interval. A standby request runs the shutdown order: hold all outputs low, stop the clock, drop the pump, then drop logic last. A standby request that arrives during any timed phase is remembered and taken when that phase ends. A status output reports the phase.

Top module: `epd_power_seq`

## Requirements
- R1: During and after synchronous reset, phase is 0 and logic_on, pump_on, pump_clk, hold_low, disp_en and xfer_req are all low.
- R2: pump_on is never high while logic_on is low, and the pump clock only toggles while pump_on is high.
- R3: In phase 0, a start_req sampled at a clock edge raises logic_on and sets phase 1 at that edge. Phase 1 lasts LOGIC_WAIT cycles. Its end raises pump_on and sets phase 2. The pump clock is enabled one cycle after pump_on rises.
- R4: pump_clk is low while disabled. Once enabled, it first rises PUMP_HALF cycles after the enable register sets, then toggles every PUMP_HALF cycles. Its period is 2*PUMP_HALF cycles; 512 Hz is the nominal rate and 250 to 1000 Hz is the legal range. It returns low one cycle after the clock is disabled.
- R5: Phase 2 continues for SETTLE_TIME cycles after the pump clock is enabled. disp_en stays low throughout.
- R6: With PREDRIVE_EN=1, phase 2 is followed by phase 3 for PREDRV_TIME cycles, with hold_low and disp_en both high. With PREDRIVE_EN=0, phase 2 goes directly to phase 4.
- R7: In phase 4, xfer_req is high and disp_en is low. A frame_ready sampled in phase 4 moves the block to phase 5 at that edge.
- R8: Phase 5 holds disp_en high and hold_low low for exactly DRIVE_TIME cycles, then returns to phase 4. The output drive is only enabled for display while the pump clock runs.
- R9: A stby_req sampled in phase 4 enters phase 6 at that edge. Phase 6 proceeds as follows: hold_low and disp_en stay high for HOLD_TIME cycles. Then both drop and the pump clock is disabled. GAP_TIME cycles later pump_on drops. GAP_TIME cycles after that, logic_on drops and phase returns to 0.
- R10: A stby_req sampled in phase 1, 2, 3 or 5 does not cut that phase short. When the phase ends, the block enters phase 6 instead of its normal successor, and the full shutdown order runs.
- R11: start_req outside phase 0, stby_req in phase 0, and frame_ready outside phase 4 have no effect.
- R12: The phase codes are: 0 standby, 1 logic-up, 2 pump-settle, 3 pre-drive, 4 transfer, 5 display, 6 shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to leave standby |
| stby_req | input | 1 | Request to enter standby |
| frame_ready | input | 1 | Frame writer has loaded a frame |
| logic_on | output | 1 | Logic-domain active control |
| pump_on | output | 1 | Charge-pump active control |
| pump_clk | output | 1 | Gated boost clock for the pump |
| hold_low | output | 1 | Command that all segment data be low |
| disp_en | output | 1 | Driver output-enable strobe |
| xfer_req | output | 1 | Frame transfer is allowed |
| phase | output | 3 | Current phase code (R12) |

## Verification
The bench builds two instances with intervals cut to a few cycles: LOGIC_WAIT=4, PUMP_HALF=3, SETTLE_TIME=20, PREDRV_TIME=6, DRIVE_TIME=15, HOLD_TIME=5 and GAP_TIME=3. One instance has pre-drive enabled and the other has it disabled. With these short intervals, three complete wake and standby cycles fit in a few hundred clocks. Every phase boundary can be checked on its exact cycle, and several pump-clock edges fall inside the settle window where they can be counted. The run covers deferral out of logic-up and out of display, and immediate standby from transfer.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;

  typedef enum logic [2:0] {
    PH_STBY   = 3'd0,
    PH_LOGIC  = 3'd1,
    PH_SETTLE = 3'd2,
    PH_PREDRV = 3'd3,
    PH_XFER   = 3'd4,
    PH_SHOW   = 3'd5,
    PH_DOWN   = 3'd6
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_interval_timer.sv
module seq_interval_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [TW-1:0] len,
  output logic          done
);

  logic [TW-1:0] cnt;
  logic          run;

  // done is high in the last cycle of a len-cycle interval started by go
  assign done = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (go) begin
      cnt <= len - 1'b1;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  // R8: an expiry that is not followed by a reload is seen only once
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    (done && !go) |=> !done);

endmodule

// File: rtl/pump_clock_gen.sv
module pump_clock_gen #(
  parameter int HALF = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic pclk
);

  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      pclk <= 1'b0;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt  <= '0;
      pclk <= ~pclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: the boost clock parks low once its enable is gone
  a_r4_low_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pclk);

endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
  import epd_seq_pkg::*;
#(
  parameter int TW          = 8,
  parameter int LOGIC_WAIT  = 4,
  parameter int SETTLE_TIME = 20,
  parameter int PREDRV_TIME = 6,
  parameter int DRIVE_TIME  = 15,
  parameter int HOLD_TIME   = 5,
  parameter int GAP_TIME    = 3,
  parameter int PREDRIVE_EN = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic          stby_req,
  input  logic          frame_ready,
  input  logic          tmr_done,
  output logic          tmr_go,
  output logic [TW-1:0] tmr_len,
  output phase_e        phase,
  output logic          logic_on,
  output logic          pump_on,
  output logic          clk_en,
  output logic          hold_low,
  output logic          disp_en,
  output logic          xfer_req
);

  phase_e     ph, nxt_ph;
  logic [1:0] sub, nxt_sub;
  logic       pend, want_down, to_down;

  // a request in the final cycle of a phase counts as well as a latched one
  assign want_down = pend | stby_req;
  assign phase     = ph;

  always_comb begin
    nxt_ph  = ph;
    nxt_sub = sub;
    tmr_go  = 1'b0;
    tmr_len = '0;
    to_down = 1'b0;
    case (ph)
      PH_STBY: begin
        if (start_req) begin
          nxt_ph  = PH_LOGIC;
          tmr_go  = 1'b1;
          tmr_len = TW'(LOGIC_WAIT);
        end
      end
      PH_LOGIC: begin
        if (tmr_done) begin
          if (want_down) to_down = 1'b1;
          else           nxt_ph  = PH_SETTLE;
        end
      end
      PH_SETTLE: begin
        if (sub == 2'd0) begin
          nxt_sub = 2'd1;
          tmr_go  = 1'b1;
          tmr_len = TW'(SETTLE_TIME);
        end else if (tmr_done) begin
          if (want_down) begin
            to_down = 1'b1;
          end else if (PREDRIVE_EN != 0) begin
            nxt_ph  = PH_PREDRV;
            tmr_go  = 1'b1;
            tmr_len = TW'(PREDRV_TIME);
          end else begin
            nxt_ph = PH_XFER;
          end
        end
      end
      PH_PREDRV: begin
        if (tmr_done) begin
          if (want_down) to_down = 1'b1;
          else           nxt_ph  = PH_XFER;
        end
      end
      PH_XFER: begin
        if (stby_req) begin
          to_down = 1'b1;
        end else if (frame_ready) begin
          nxt_ph  = PH_SHOW;
          tmr_go  = 1'b1;
          tmr_len = TW'(DRIVE_TIME);
        end
      end
      PH_SHOW: begin
        if (tmr_done) begin
          if (want_down) to_down = 1'b1;
          else           nxt_ph  = PH_XFER;
        end
      end
      PH_DOWN: begin
        if (tmr_done) begin
          if (sub == 2'd0) begin
            nxt_sub = 2'd1;
            tmr_go  = 1'b1;
            tmr_len = TW'(GAP_TIME);
          end else if (sub == 2'd1) begin
            nxt_sub = 2'd2;
            tmr_go  = 1'b1;
            tmr_len = TW'(GAP_TIME);
          end else begin
            nxt_ph = PH_STBY;
          end
        end
      end
      default: nxt_ph = PH_STBY;
    endcase
    if (nxt_ph != ph) nxt_sub = 2'd0;
    if (to_down) begin
      nxt_ph  = PH_DOWN;
      nxt_sub = 2'd0;
      tmr_go  = 1'b1;
      tmr_len = TW'(HOLD_TIME);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_STBY;
      sub      <= 2'd0;
      pend     <= 1'b0;
      logic_on <= 1'b0;
      pump_on  <= 1'b0;
      clk_en   <= 1'b0;
      hold_low <= 1'b0;
      disp_en  <= 1'b0;
      xfer_req <= 1'b0;
    end else begin
      ph  <= nxt_ph;
      sub <= nxt_sub;
      if (nxt_ph == PH_DOWN && ph != PH_DOWN)
        pend <= 1'b0;
      else if (stby_req && ph != PH_STBY && ph != PH_DOWN)
        pend <= 1'b1;
      logic_on <= (nxt_ph != PH_STBY);
      if (nxt_ph == PH_SETTLE)
        pump_on <= 1'b1;
      else if (nxt_ph == PH_STBY || (nxt_ph == PH_DOWN && nxt_sub == 2'd2))
        pump_on <= 1'b0;
      if (nxt_ph == PH_SETTLE && nxt_sub == 2'd1)
        clk_en <= 1'b1;
      else if (nxt_ph == PH_STBY || (nxt_ph == PH_DOWN && nxt_sub != 2'd0))
        clk_en <= 1'b0;
      hold_low <= (nxt_ph == PH_PREDRV) || (nxt_ph == PH_DOWN && nxt_sub == 2'd0);
      disp_en  <= (nxt_ph == PH_PREDRV) || (nxt_ph == PH_SHOW) ||
                  (nxt_ph == PH_DOWN && nxt_sub == 2'd0);
      xfer_req <= (nxt_ph == PH_XFER);
    end
  end

  // R2: the pump never runs with logic in standby
  a_r2_pump_needs_logic: assert property (@(posedge clk) disable iff (rst)
    pump_on |-> logic_on);
  // R2: the boost clock is only enabled on a powered pump
  a_r2_clk_needs_pump: assert property (@(posedge clk) disable iff (rst)
    clk_en |-> pump_on);
  // R3: logic is already up when the pump is switched on
  a_r3_logic_before_pump: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_on) |-> $past(logic_on));
  // R9: the pump is already off when logic drops
  a_r9_logic_last: assert property (@(posedge clk) disable iff (rst)
    $fell(logic_on) |-> !$past(pump_on));
  // R9: the clock is already stopped when the pump drops
  a_r9_clk_before_pump: assert property (@(posedge clk) disable iff (rst)
    $fell(pump_on) |-> !$past(clk_en));
  // R8: data is only shown while the pump clock runs
  a_r8_show_needs_clock: assert property (@(posedge clk) disable iff (rst)
    (disp_en && !hold_low) |-> clk_en);
  // R12: only the seven defined phase codes occur
  a_r12_phase_legal: assert property (@(posedge clk) disable iff (rst)
    ph != phase_e'(3'd7));

endmodule

// File: rtl/epd_power_seq.sv
module epd_power_seq
  import epd_seq_pkg::*;
#(
  parameter int PUMP_HALF   = 32,
  parameter int LOGIC_WAIT  = 33,
  parameter int SETTLE_TIME = 197,
  parameter int PREDRV_TIME = 492,
  parameter int DRIVE_TIME  = 21300,
  parameter int HOLD_TIME   = 33,
  parameter int GAP_TIME    = 2,
  parameter int PREDRIVE_EN = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_req,
  input  logic       stby_req,
  input  logic       frame_ready,
  output logic       logic_on,
  output logic       pump_on,
  output logic       pump_clk,
  output logic       hold_low,
  output logic       disp_en,
  output logic       xfer_req,
  output logic [2:0] phase
);

  localparam int LONGEST = imax(imax(imax(LOGIC_WAIT, SETTLE_TIME),
                                     imax(PREDRV_TIME, DRIVE_TIME)),
                                imax(HOLD_TIME, GAP_TIME));
  localparam int TW = $clog2(LONGEST + 1);

  logic          tmr_go, tmr_done, clk_en;
  logic [TW-1:0] tmr_len;
  phase_e        fsm_phase;

  seq_phase_fsm #(
    .TW(TW), .LOGIC_WAIT(LOGIC_WAIT), .SETTLE_TIME(SETTLE_TIME),
    .PREDRV_TIME(PREDRV_TIME), .DRIVE_TIME(DRIVE_TIME),
    .HOLD_TIME(HOLD_TIME), .GAP_TIME(GAP_TIME), .PREDRIVE_EN(PREDRIVE_EN)
  ) u_fsm (
    .clk(clk), .rst(rst), .start_req(start_req), .stby_req(stby_req),
    .frame_ready(frame_ready), .tmr_done(tmr_done), .tmr_go(tmr_go),
    .tmr_len(tmr_len), .phase(fsm_phase), .logic_on(logic_on),
    .pump_on(pump_on), .clk_en(clk_en), .hold_low(hold_low),
    .disp_en(disp_en), .xfer_req(xfer_req)
  );

  seq_interval_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .go(tmr_go), .len(tmr_len), .done(tmr_done)
  );

  pump_clock_gen #(.HALF(PUMP_HALF)) u_pclk (
    .clk(clk), .rst(rst), .en(clk_en), .pclk(pump_clk)
  );

  assign phase = fsm_phase;

  // R2: no boost clock edge reaches an unpowered pump
  a_r2_pclk_within_pump: assert property (@(posedge clk) disable iff (rst)
    pump_clk |-> pump_on);

endmodule

// File: tb/epd_power_seq_test.sv
module epd_power_seq_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int LW = 4, HALF = 3, SETTLE = 20, PRE = 6, DRIVE = 15, HOLD = 5, GAP = 3;
  localparam logic [8:0] M_ALL = 9'h1FF, M_NOCLK = 9'h1F7, M_CLK = 9'h008, M_PH = 9'h1C0;

  typedef struct {
    int         at;
    int         unit;
    logic [8:0] mask;
    logic [8:0] val;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic start_req = 1'b0, stby_req = 1'b0, frame_ready = 1'b0;
  logic lo_a, pu_a, pc_a, hl_a, de_a, xr_a, lo_b, pu_b, pc_b, hl_b, de_b, xr_b;
  logic [2:0] ph_a, ph_b;
  logic [8:0] obs_a, obs_b, mon_got;
  exp_t q[$];
  exp_t mon_it;
  int cyc = 0, checks = 0, errors = 0;
  bit finished = 0, bad_combo = 0;
  int c, e, x, d, f, s0, c2, c3, x3;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  epd_power_seq #(.PUMP_HALF(HALF), .LOGIC_WAIT(LW), .SETTLE_TIME(SETTLE),
    .PREDRV_TIME(PRE), .DRIVE_TIME(DRIVE), .HOLD_TIME(HOLD), .GAP_TIME(GAP),
    .PREDRIVE_EN(1)) uut (
    .clk(clk), .rst(rst), .start_req(start_req), .stby_req(stby_req),
    .frame_ready(frame_ready), .logic_on(lo_a), .pump_on(pu_a), .pump_clk(pc_a),
    .hold_low(hl_a), .disp_en(de_a), .xfer_req(xr_a), .phase(ph_a));

  epd_power_seq #(.PUMP_HALF(HALF), .LOGIC_WAIT(LW), .SETTLE_TIME(SETTLE),
    .PREDRV_TIME(PRE), .DRIVE_TIME(DRIVE), .HOLD_TIME(HOLD), .GAP_TIME(GAP),
    .PREDRIVE_EN(0)) uut_skip (
    .clk(clk), .rst(rst), .start_req(start_req), .stby_req(stby_req),
    .frame_ready(frame_ready), .logic_on(lo_b), .pump_on(pu_b), .pump_clk(pc_b),
    .hold_low(hl_b), .disp_en(de_b), .xfer_req(xr_b), .phase(ph_b));

  assign obs_a = {ph_a, lo_a, pu_a, pc_a, hl_a, de_a, xr_a};
  assign obs_b = {ph_b, lo_b, pu_b, pc_b, hl_b, de_b, xr_b};

  function automatic logic [8:0] pk(input int ph, input logic lo, input logic pu,
                                    input logic pc, input logic hl, input logic de,
                                    input logic xr);
    logic [2:0] p3;
    p3 = ph[2:0];
    return {p3, lo, pu, pc, hl, de, xr};
  endfunction

  // driver side: expected observations, kept ordered by cycle
  task automatic expect_at(input int at, input int unit, input logic [8:0] m,
                           input logic [8:0] v, input string tag);
    exp_t it;
    int i;
    it.at = at; it.unit = unit; it.mask = m; it.val = v & m; it.tag = tag;
    i = 0;
    while (i < q.size() && q[i].at <= at) i++;
    q.insert(i, it);
  endtask

  task automatic goto(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor side: pops and compares away from the active edge
  always @(negedge clk) begin
    if ((pu_a && !lo_a) || (pu_b && !lo_b) || (pc_a && !pu_a) || (pc_b && !pu_b))
      bad_combo = 1;
    while (q.size() > 0 && q[0].at <= cyc) begin
      mon_it  = q.pop_front();
      mon_got = ((mon_it.unit == 0) ? obs_a : obs_b) & mon_it.mask;
      checks++;
      if (mon_it.at < cyc) begin
        errors++;
        $display("FAIL %s: check for cycle %0d missed (now %0d), got %h expected %h",
                 mon_it.tag, mon_it.at, cyc, mon_got, mon_it.val);
      end else if (mon_got !== mon_it.val) begin
        errors++;
        $display("FAIL %s at cycle %0d unit %0d: got %h expected %h (mask %h)",
                 mon_it.tag, cyc, mon_it.unit, mon_got, mon_it.val, mon_it.mask);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung at cycle %0d, got running expected finished", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state on both instances
    expect_at(2, 0, M_ALL, pk(0,0,0,0,0,0,0), "R1 reset state");
    expect_at(2, 1, M_ALL, pk(0,0,0,0,0,0,0), "R1 reset state skip");
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11: standby request and frame-ready in standby do nothing
    c = cyc + 1;
    goto(c);
    stby_req = 1'b1; frame_ready = 1'b1;
    expect_at(c + 1, 0, M_ALL, pk(0,0,0,0,0,0,0), "R11 stby/frame ignored in standby");
    expect_at(c + 3, 0, M_ALL, pk(0,0,0,0,0,0,0), "R11 still standby");
    goto(c + 1);
    stby_req = 1'b0; frame_ready = 1'b0;

    // R3 startup order
    c = cyc + 2;
    goto(c);
    start_req = 1'b1;
    e = c + 2 + LW;
    x = e + SETTLE + PRE;
    expect_at(c + 1,      0, M_ALL,   pk(1,1,0,0,0,0,0), "R3 logic up first, R12 code 1");
    expect_at(c + LW,     0, M_NOCLK, pk(1,1,0,0,0,0,0), "R3 pump still off");
    expect_at(c + 1 + LW, 0, M_ALL,   pk(2,1,1,0,0,0,0), "R3 pump on before clock, R12 code 2");
    expect_at(c + 1 + LW, 1, M_ALL,   pk(2,1,1,0,0,0,0), "R3 pump on skip");
    expect_at(e + HALF - 1,     0, M_CLK, 9'h000, "R4 clock low before first half period");
    expect_at(e + HALF,         0, M_CLK, 9'h008, "R4 first rising edge");
    expect_at(e + 2 * HALF - 1, 0, M_CLK, 9'h008, "R4 high half period");
    expect_at(e + 2 * HALF,     0, M_CLK, 9'h000, "R4 falling edge");
    expect_at(e + 3 * HALF,     0, M_CLK, 9'h008, "R4 full period");
    expect_at(e + SETTLE - 1, 0, M_NOCLK, pk(2,1,1,0,0,0,0), "R5 still settling, display off");
    expect_at(e + SETTLE,     0, M_NOCLK, pk(3,1,1,0,1,1,0), "R6 pre-drive low, R12 code 3");
    expect_at(e + SETTLE,     1, M_NOCLK, pk(4,1,1,0,0,0,1), "R6 pre-drive skipped");
    expect_at(x - 1, 0, M_NOCLK, pk(3,1,1,0,1,1,0), "R6 pre-drive length");
    expect_at(x,     0, M_NOCLK, pk(4,1,1,0,0,0,1), "R7 transfer phase, R12 code 4");
    goto(c + 1);
    start_req = 1'b0;

    // R11 start ignored in transfer
    goto(x + 2);
    start_req = 1'b1;
    expect_at(x + 4, 0, M_NOCLK, pk(4,1,1,0,0,0,1), "R11 start ignored in transfer");
    goto(x + 3);
    start_req = 1'b0;

    // R7/R8 frame display
    d = x + 6;
    goto(d);
    frame_ready = 1'b1;
    expect_at(d + 1,         0, M_NOCLK, pk(5,1,1,0,0,1,0), "R7 frame accepted, R12 code 5");
    expect_at(d + DRIVE,     0, M_NOCLK, pk(5,1,1,0,0,1,0), "R8 display held");
    expect_at(d + 1 + DRIVE, 0, M_NOCLK, pk(4,1,1,0,0,0,1), "R8 back to transfer");
    expect_at(d + 1 + DRIVE, 1, M_NOCLK, pk(4,1,1,0,0,0,1), "R8 back to transfer skip");
    goto(d + 1);
    frame_ready = 1'b0;
    goto(d + 3);
    start_req = 1'b1;
    goto(d + 4);
    start_req = 1'b0;
    goto(d + 5);
    frame_ready = 1'b1;
    goto(d + 6);
    frame_ready = 1'b0;

    // R10 deferral from display, then R9 shutdown order
    f = d + 3 + DRIVE;
    goto(f);
    frame_ready = 1'b1;
    s0 = f + 1 + DRIVE;
    expect_at(f + 1,   0, M_NOCLK, pk(5,1,1,0,0,1,0), "R7 second frame");
    expect_at(f + DRIVE, 0, M_NOCLK, pk(5,1,1,0,0,1,0), "R10 display not cut short");
    expect_at(s0,      0, M_NOCLK, pk(6,1,1,0,1,1,0), "R10 deferred into shutdown, R12 code 6");
    expect_at(s0 + HOLD - 1, 0, M_NOCLK, pk(6,1,1,0,1,1,0), "R9 outputs held low");
    expect_at(s0 + HOLD,     0, M_NOCLK, pk(6,1,1,0,0,0,0), "R9 hold released, clock stopped");
    expect_at(s0 + HOLD + 1, 0, M_ALL,   pk(6,1,1,0,0,0,0), "R9 pump clock low");
    expect_at(s0 + HOLD + GAP - 1, 0, M_ALL, pk(6,1,1,0,0,0,0), "R9 pump held through gap");
    expect_at(s0 + HOLD + GAP,     0, M_ALL, pk(6,1,0,0,0,0,0), "R9 pump off before logic");
    expect_at(s0 + HOLD + 2 * GAP - 1, 0, M_ALL, pk(6,1,0,0,0,0,0), "R9 logic held through gap");
    expect_at(s0 + HOLD + 2 * GAP,     0, M_ALL, pk(0,0,0,0,0,0,0), "R9 logic off last");
    expect_at(s0 + HOLD + 2 * GAP,     1, M_ALL, pk(0,0,0,0,0,0,0), "R9 skip back in standby");
    goto(f + 1);
    frame_ready = 1'b0;
    goto(f + 4);
    stby_req = 1'b1;
    goto(f + 5);
    stby_req = 1'b0;

    // R10 deferral out of logic-up
    c2 = s0 + HOLD + 2 * GAP + 3;
    goto(c2);
    start_req = 1'b1;
    expect_at(c2 + LW,     0, M_ALL, pk(1,1,0,0,0,0,0), "R10 logic-up not cut short");
    expect_at(c2 + 1 + LW, 0, M_ALL, pk(6,1,0,0,1,1,0), "R10 shutdown instead of pump-settle");
    expect_at(c2 + 1 + LW + HOLD + GAP, 0, M_ALL, pk(6,1,0,0,0,0,0), "R10 pump never started");
    expect_at(c2 + 1 + LW + HOLD + 2 * GAP, 0, M_ALL, pk(0,0,0,0,0,0,0), "R10 back in standby");
    goto(c2 + 1);
    start_req = 1'b0; stby_req = 1'b1;
    goto(c2 + 2);
    stby_req = 1'b0;

    // R9 immediate standby from transfer
    c3 = c2 + 1 + LW + HOLD + 2 * GAP + 3;
    goto(c3);
    start_req = 1'b1;
    x3 = c3 + 2 + LW + SETTLE + PRE;
    expect_at(x3,     0, M_NOCLK, pk(4,1,1,0,0,0,1), "R7 transfer after restart");
    expect_at(x3 + 2, 0, M_NOCLK, pk(6,1,1,0,1,1,0), "R9 immediate shutdown from transfer");
    expect_at(x3 + 2, 1, M_NOCLK, pk(6,1,1,0,1,1,0), "R9 immediate shutdown skip");
    expect_at(x3 + 2 + HOLD + 2 * GAP, 0, M_ALL, pk(0,0,0,0,0,0,0), "R9 standby reached");
    expect_at(x3 + 2 + HOLD + 2 * GAP, 1, M_PH,  pk(0,0,0,0,0,0,0), "R12 skip standby code 0");
    goto(c3 + 1);
    start_req = 1'b0;
    goto(x3 + 1);
    stby_req = 1'b1;
    goto(x3 + 2);
    stby_req = 1'b0;

    goto(x3 + HOLD + 2 * GAP + 6);
    while (q.size() > 0) @(negedge clk);
    checks++;
    if (bad_combo) begin
      errors++;
      $display("FAIL R2: illegal pump/logic/clock combination seen, got 1 expected 0");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule